// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address by fetching two words from memory. A root base input names the physical start of a top-level directory. The upper ten bits of the linear address pick a directory entry. That entry points at a second-level table, and the next ten bits pick an entry in that table. The low twelve bits are copied into the physical address unchanged. Each level holds 1024 four-byte entries, so one level fills exactly one 4 KiB page.

The block takes one request at a time through a valid/ready handshake. The request carries the linear address and a write flag. The block issues word reads on a request/response memory port. It then presents either the physical address or a fault with its cause and the faulting linear address. The result is held until the consumer accepts it. Read-only pages make copy-on-write possible: a write to such a page faults, while a read of the same page succeeds. The translation depends only on the root base and on the table contents. Two roots may therefore map the same linear address to different frames. Two linear addresses may also share a frame.

Top module: `ptw_top`

## Requirements
- R1: The first memory read after a request is accepted goes to address root_base + (linear[31:22] × 4). root_base is sampled when the request is accepted.
- R2: When the directory entry is present, the second read goes to {directory entry[31:12], 12'b0} + (linear[21:12] × 4).
- R3: A directory entry with bit 0 clear ends the walk with res_fault=1 and res_cause=0, after exactly one memory read.
- R4: A table entry with bit 0 clear ends the walk with res_fault=1 and res_cause=1, after exactly two memory reads.
- R5: A successful walk gives res_fault=0 and res_paddr = {table entry[31:12], linear[11:0]}.
- R6: A write is allowed only when bit 1 (writable) is set in both the directory entry and the table entry. Otherwise a write gives res_fault=1 with res_cause=2, and a read of the same address still succeeds.
- R7: Entry bits [11:2] have no effect on the walk.
- R8: req_ready is low from the cycle after acceptance until the result handshake (res_valid and res_ready both high) completes. While res_valid is high and res_ready is low, the result outputs hold steady.
- R9: res_vaddr carries the linear address of the walk. res_paddr is 0 when res_fault is 1.
- R10: The same linear address under two different root_base values follows each root's own tables. Two linear addresses whose tables give the same frame both return that frame.
- R11: mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen high. At most one read is outstanding at any time.
- R12: After reset, req_ready=1, mem_req_valid=0 and res_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical base of the directory, sampled when a request is accepted |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_fault | output | 1 | 1 when the walk faulted |
| res_cause | output | 2 | Fault cause: 0 directory absent, 1 table absent, 2 write to read-only |
| res_paddr | output | 32 | Translated physical address (0 on fault) |
| res_vaddr | output | 32 | Linear address of this walk |

## Verification
The bench builds the walker with its default parameters: a 32-bit linear and physical address split 10/10/12 and four-byte entries. With these values the directory and table index arithmetic, the frame/offset join and the 4 KiB table alignment can all be predicted by hand. Its memory responder runs with zero and with three cycles of latency. This puts both back-to-back handshakes and long stalls of the read request within reach. Two directories built under different roots, together with a shared second-level table, bring both root-dependent mapping and aliasing to the ports.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry attribute bit positions (decoded by the walker)
  localparam int ENT_PRESENT_BIT  = 0;
  localparam int ENT_WRITABLE_BIT = 1;

  typedef enum logic [1:0] {
    CAUSE_DIR_ABSENT = 2'd0,
    CAUSE_TBL_ABSENT = 2'd1,
    CAUSE_WRITE_RO   = 2'd2
  } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
  parameter int VA_W      = 32,
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  localparam int OFF_W    = VA_W - DIR_IDX_W - TBL_IDX_W
) (
  input  logic [VA_W-1:0]      vaddr,
  output logic [DIR_IDX_W-1:0] dir_idx,
  output logic [TBL_IDX_W-1:0] tbl_idx,
  output logic [OFF_W-1:0]     offset
);
  assign dir_idx = vaddr[VA_W-1 -: DIR_IDX_W];
  assign tbl_idx = vaddr[OFF_W +: TBL_IDX_W];
  assign offset  = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W        = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int PAD_W = PA_W - IDX_W - ENTRY_SHIFT;

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    logic [PA_W-1:0] scaled;
    scaled = {{PAD_W{1'b0}}, i, {ENTRY_SHIFT{1'b0}}};
    return b + scaled;
  endfunction

  assign entry_addr = slot_addr(base, idx);
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ENTRY_W = 32,
  parameter int FRAME_W = 20
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic               writable,
  output logic [FRAME_W-1:0] frame,
  output logic [ENTRY_W-FRAME_W-3:0] spare
);
  import ptw_pkg::*;
  assign present  = entry[ENT_PRESENT_BIT];
  assign writable = entry[ENT_WRITABLE_BIT];
  assign frame    = entry[ENTRY_W-1 -: FRAME_W];
  assign spare    = entry[ENTRY_W-FRAME_W-1:2];
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int ENTRY_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [8*ENTRY_BYTES-1:0] mem_rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_fault,
  output logic [1:0]      res_cause,
  output logic [PA_W-1:0] res_paddr,
  output logic [VA_W-1:0] res_vaddr
);
  import ptw_pkg::*;

  localparam int OFF_W       = VA_W - DIR_IDX_W - TBL_IDX_W;
  localparam int FRAME_W     = PA_W - OFF_W;
  localparam int ENTRY_W     = 8 * ENTRY_BYTES;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int SPARE_W     = ENTRY_W - FRAME_W - 2;

  walk_state_e          state_q;
  logic [VA_W-1:0]      vaddr_q;
  logic                 write_q;
  logic [PA_W-1:0]      root_q;
  logic [FRAME_W-1:0]   dir_frame_q;
  logic                 dir_wr_q;
  logic                 fault_q;
  fault_cause_e         cause_q;
  logic [PA_W-1:0]      paddr_q;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0]     offset;
  logic [PA_W-1:0]      dir_entry_addr;
  logic [PA_W-1:0]      tbl_entry_addr;
  logic [PA_W-1:0]      tbl_base;
  logic                 ent_present;
  logic                 ent_writable;
  logic [FRAME_W-1:0]   ent_frame;
  logic [SPARE_W-1:0]   ent_spare;

  // Named events for observation
  logic walk_accept;
  logic dir_rsp_evt;
  logic tbl_rsp_evt;
  logic result_taken;
  logic write_denied;

  ptw_index_split #(.VA_W(VA_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W)) u_split (
    .vaddr  (vaddr_q),
    .dir_idx(dir_idx),
    .tbl_idx(tbl_idx),
    .offset (offset)
  );

  assign tbl_base = {dir_frame_q, {OFF_W{1'b0}}};

  ptw_entry_addr #(.PA_W(PA_W), .IDX_W(DIR_IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_dir_addr (
    .base      (root_q),
    .idx       (dir_idx),
    .entry_addr(dir_entry_addr)
  );

  ptw_entry_addr #(.PA_W(PA_W), .IDX_W(TBL_IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_tbl_addr (
    .base      (tbl_base),
    .idx       (tbl_idx),
    .entry_addr(tbl_entry_addr)
  );

  ptw_entry_decode #(.ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W)) u_decode (
    .entry   (mem_rsp_data),
    .present (ent_present),
    .writable(ent_writable),
    .frame   (ent_frame),
    .spare   (ent_spare)
  );

  assign walk_accept  = (state_q == ST_IDLE) && req_valid;
  assign dir_rsp_evt  = (state_q == ST_DIR_WAIT) && mem_rsp_valid;
  assign tbl_rsp_evt  = (state_q == ST_TBL_WAIT) && mem_rsp_valid;
  assign result_taken = (state_q == ST_DONE) && res_ready;
  assign write_denied = write_q && !(dir_wr_q && ent_writable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      write_q     <= 1'b0;
      root_q      <= '0;
      dir_frame_q <= '0;
      dir_wr_q    <= 1'b0;
      fault_q     <= 1'b0;
      cause_q     <= CAUSE_DIR_ABSENT;
      paddr_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (walk_accept) begin
          vaddr_q <= req_vaddr;
          write_q <= req_write;
          root_q  <= root_base;
          state_q <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (dir_rsp_evt) begin
          if (!ent_present) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_DIR_ABSENT;
            paddr_q <= '0;
            state_q <= ST_DONE;
          end else begin
            dir_frame_q <= ent_frame;
            dir_wr_q    <= ent_writable;
            state_q     <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_req_ready) state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (tbl_rsp_evt) begin
          state_q <= ST_DONE;
          if (!ent_present) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_TBL_ABSENT;
            paddr_q <= '0;
          end else if (write_denied) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_WRITE_RO;
            paddr_q <= '0;
          end else begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_DIR_ABSENT;
            paddr_q <= {ent_frame, offset};
          end
        end
        ST_DONE: if (result_taken) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_req_addr  = (state_q == ST_TBL_REQ) ? tbl_entry_addr : dir_entry_addr;
  assign res_valid     = (state_q == ST_DONE);
  assign res_fault     = fault_q;
  assign res_cause     = cause_q;
  assign res_paddr     = paddr_q;
  assign res_vaddr     = vaddr_q;

endmodule

// File: rtl/ptw_checks.sv
module ptw_checks #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_fault,
  input logic [1:0]      res_cause,
  input logic [PA_W-1:0] res_paddr,
  input logic [VA_W-1:0] res_vaddr,
  input logic            walk_accept,
  input logic            dir_rsp_evt,
  input logic            tbl_rsp_evt,
  input logic            ent_spare_any
);
  logic [1:0] reads_q;

  always_ff @(posedge clk) begin
    if (!rst_n) reads_q <= 2'd0;
    else if (req_valid && req_ready) reads_q <= 2'd0;
    else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
  end

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_busy_until_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !(res_valid && res_ready)) |=> !req_ready);

  p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_paddr) &&
      $stable(res_cause) && $stable(res_fault) && $stable(res_vaddr));

  p_memreq_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

  p_dir_fault_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault && res_cause == 2'd0) |-> reads_q == 2'd1);

  p_tbl_fault_two_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault && res_cause == 2'd1) |-> reads_q == 2'd2);

  p_success_join_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (reads_q == 2'd2 &&
      res_paddr[OFF_W-1:0] == res_vaddr[OFF_W-1:0]));

  p_fault_paddr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0 && res_cause != 2'd3));

  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({walk_accept, dir_rsp_evt, tbl_rsp_evt, mem_req_valid && mem_req_ready}));

  p_spare_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rsp_evt && ent_spare_any) |-> !res_valid);

endmodule

bind ptw_top ptw_checks #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ptw_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_fault    (res_fault),
  .res_cause    (res_cause),
  .res_paddr    (res_paddr),
  .res_vaddr    (res_vaddr),
  .walk_accept  (walk_accept),
  .dir_rsp_evt  (dir_rsp_evt),
  .tbl_rsp_evt  (tbl_rsp_evt),
  .ent_spare_any(|ent_spare)
);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic [1:0]  res_cause;
  logic [31:0] res_paddr;
  logic [31:0] res_vaddr;

  always #4 clk = ~clk; // 125 MHz

  ptw_top dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_cause(res_cause), .res_paddr(res_paddr), .res_vaddr(res_vaddr)
  );

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  bit done   = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [4];
  int rd_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && !mem_req_ready) begin
        logic [31:0] a;
        a = mem_req_addr;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a, "R11 request held", mem_req_addr, a);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(!mem_req_valid, "R11 single outstanding", {31'd0, mem_req_valid}, 32'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(a) ? mem[a] : 32'd0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  // One walk; returns the result fields
  task automatic walk(input logic [31:0] root, input logic [31:0] va, input bit wr,
                      output bit flt, output logic [1:0] cause, output logic [31:0] pa);
    int n;
    logic [31:0] hold_pa;
    logic [1:0]  hold_c;
    rd_cnt = 0;
    @(negedge clk);
    root_base = root; req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    root_base = 32'hFFFF_0000; // later changes must not matter
    chk(!req_ready, "R8 busy after accept", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!res_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(res_vaddr == va, "R9 vaddr reported", res_vaddr, va);
    hold_pa = res_paddr; hold_c = res_cause;
    @(negedge clk);
    chk(res_valid && res_paddr == hold_pa && res_cause == hold_c, "R8 result held",
        res_paddr, hold_pa);
    chk(!req_ready, "R8 busy until taken", {31'd0, req_ready}, 32'd0);
    flt = res_fault; cause = res_cause; pa = res_paddr;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(req_ready && !res_valid, "R8 idle after handshake", {30'd0, req_ready, res_valid}, 32'd2);
  endtask

  localparam logic [31:0] ROOT_A = 32'h0001_0000;
  localparam logic [31:0] ROOT_B = 32'h0003_0000;

  task automatic t_reset();
    chk(req_ready == 1'b1, "R12 req_ready", {31'd0, req_ready}, 32'd1);
    chk(mem_req_valid == 1'b0, "R12 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    chk(res_valid == 1'b0, "R12 res_valid", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_basic(input int l);
    bit f; logic [1:0] c; logic [31:0] p;
    lat = l;
    walk(ROOT_A, 32'h0040_3ABC, 1'b1, f, c, p);
    chk(rd_cnt == 2, "R2 two reads", rd_cnt, 2);
    chk(rd_log[0] == 32'h0001_0004, "R1 directory read address", rd_log[0], 32'h0001_0004);
    chk(rd_log[1] == 32'h0002_000C, "R2 table read address", rd_log[1], 32'h0002_000C);
    chk(!f && p == 32'h1234_5ABC, "R5 translated address", p, 32'h1234_5ABC);
  endtask

  task automatic t_dir_absent();
    bit f; logic [1:0] c; logic [31:0] p;
    lat = 0;
    walk(ROOT_A, 32'h00C0_0040, 1'b0, f, c, p);
    chk(f && c == 2'd0, "R3 directory absent cause", {30'd0, c}, 32'd0);
    chk(rd_cnt == 1, "R3 single read", rd_cnt, 1);
    chk(p == 32'd0, "R9 paddr zero on fault", p, 32'd0);
  endtask

  task automatic t_tbl_absent();
    bit f; logic [1:0] c; logic [31:0] p;
    lat = 3;
    walk(ROOT_A, 32'h0040_5000, 1'b0, f, c, p);
    chk(f && c == 2'd1, "R4 table absent cause", {30'd0, c}, 32'd1);
    chk(rd_cnt == 2, "R4 two reads", rd_cnt, 2);
  endtask

  task automatic t_readonly();
    bit f; logic [1:0] c; logic [31:0] p;
    lat = 0;
    walk(ROOT_A, 32'h0040_4010, 1'b1, f, c, p);
    chk(f && c == 2'd2, "R6 write to read-only page", {30'd0, c}, 32'd2);
    walk(ROOT_A, 32'h0040_4010, 1'b0, f, c, p);
    chk(!f && p == 32'h0005_5010, "R6 read of read-only page", p, 32'h0005_5010);
    walk(ROOT_A, 32'h0080_0123, 1'b1, f, c, p);
    chk(f && c == 2'd2, "R6 write under read-only directory", {30'd0, c}, 32'd2);
    walk(ROOT_A, 32'h0080_0123, 1'b0, f, c, p);
    chk(!f && p == 32'h0006_6123, "R6 read under read-only directory", p, 32'h0006_6123);
  endtask

  task automatic t_spare_bits();
    bit f; logic [1:0] c; logic [31:0] p;
    lat = 0;
    walk(ROOT_A, 32'h0040_6777, 1'b1, f, c, p);
    chk(!f && p == 32'h0007_7777, "R7 table spare bits ignored", p, 32'h0007_7777);
    walk(ROOT_A, 32'h0100_3ABC, 1'b1, f, c, p);
    chk(rd_log[1] == 32'h0002_000C, "R7 directory spare bits ignored", rd_log[1], 32'h0002_000C);
    chk(!f && p == 32'h1234_5ABC, "R10 alias to shared frame", p, 32'h1234_5ABC);
  endtask

  task automatic t_roots();
    bit f; logic [1:0] c; logic [31:0] p;
    lat = 1;
    walk(ROOT_B, 32'h0040_3ABC, 1'b0, f, c, p);
    chk(rd_log[0] == 32'h0003_0004, "R1 root sampled at accept", rd_log[0], 32'h0003_0004);
    chk(!f && p == 32'h0009_9ABC, "R10 second root mapping", p, 32'h0009_9ABC);
  endtask

  initial begin
    // Entry layout: bit0 present, bit1 writable, [31:12] frame
    mem[32'h0001_0004] = 32'h0002_0003; // dir A[1] -> table 0x20000, rw
    mem[32'h0001_0008] = 32'h0002_1001; // dir A[2] -> table 0x21000, ro
    mem[32'h0001_000C] = 32'h0002_2002; // dir A[3] absent
    mem[32'h0001_0010] = 32'h0002_0FF3; // dir A[4] -> table 0x20000, spare bits set
    mem[32'h0002_000C] = 32'h1234_5003;
    mem[32'h0002_0010] = 32'h0005_5001; // read-only page
    mem[32'h0002_0014] = 32'hABCD_EFFE; // absent
    mem[32'h0002_0018] = 32'h0007_7FFB; // spare bits set
    mem[32'h0002_1000] = 32'h0006_6003;
    mem[32'h0003_0004] = 32'h0004_0003; // dir B[1]
    mem[32'h0004_000C] = 32'h0009_9003;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic(0);
    t_basic(3);
    t_dir_absent();
    t_tbl_absent();
    t_readonly();
    t_spare_bits();
    t_roots();
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule